// File: doc/BRIEF.md
# Dual-Read-Port Register File

This block is a bank of general-purpose registers for a simple load-store datapath. It has one write port and two independent read ports. A write is taken on the rising clock edge, and only while the write strobe is high. The write address goes through a two-level decode that produces a one-hot select, and only the selected register captures the data.

Each read port has its own address and returns the addressed word combinationally from the current contents. Entry zero is wired to zero: it holds nothing and ignores writes. There is no bypass path. A read of the entry being written in the same cycle returns the old value until the clock edge has passed.

Top module: `regbank_2r1w`

## Requirements
- R1: A synchronous active-high reset clears every entry to zero, so both ports read zero afterwards.
- R2: When the write strobe is high on a rising edge, the entry at the write address takes the write data. No other entry changes.
- R3: When the write strobe is low, no entry changes, and every bit of the internal one-hot write select is zero.
- R4: When the write strobe is high, the internal write select has exactly one bit set, at the bit position equal to the write address.
- R5: Entry 0 always reads as zero on both ports, even after an enabled write to address 0.
- R6: Both read ports return their own addressed entries at the same time. This holds when the two addresses differ and when they are equal.
- R7: Reads are combinational with no bypass. A read of the address being written returns the old value before the edge and the new value after it.
- R8: The write select is built in two levels. Address bits [4:1] pick a pair of entries, and bit 0 together with the strobe picks one entry of that pair (bit 0 = 0 gives the even entry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write entry index |
| wr_data | input | 32 | Write word |
| rd_addr_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A word |
| rd_addr_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B word |

## Verification
A wrong write select corrupts an entry other than the addressed one. That shows at the ports only when the bench reads that entry, so after each write the bench reads back every entry on both ports against a reference model. A stuck or leaking entry 0 shows as a nonzero word at address 0 on the first read after the write. A missing or extra bypass shows within the same cycle as the write, when the bench reads the written address just before the clock edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned RB_WORD_W  = 32;
  localparam int unsigned RB_ADDR_W  = 5;
  localparam int unsigned RB_ENTRIES = 1 << RB_ADDR_W;

  // Pair index taken from the upper address bits.
  function automatic logic [RB_ADDR_W-2:0] pair_of(input logic [RB_ADDR_W-1:0] a);
    return a[RB_ADDR_W-1:1];
  endfunction
endpackage

// File: rtl/regbank_wsel.sv
module regbank_wsel #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned N     = 1 << ADDR_W,
  localparam int unsigned PAIRS = N / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      sel
);
  logic [PAIRS-1:0] pair_hit;

  // Level 1: the upper address bits pick one pair.
  always_comb begin
    pair_hit = '0;
    pair_hit[addr[ADDR_W-1:1]] = 1'b1;
  end

  // Level 2: the low bit and the strobe pick one entry of the pair.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign sel[2*p]   = pair_hit[p] & en & ~addr[0];
    assign sel[2*p+1] = pair_hit[p] & en &  addr[0];
  end

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst) !en |-> sel == '0)
    else $error("write select active while strobe low");
  p_onehot_r4: assert property (@(posedge clk) disable iff (rst) en |-> $countones(sel) == 1)
    else $error("write select not one-hot");
  p_pos_r8: assert property (@(posedge clk) disable iff (rst) en |-> sel[addr])
    else $error("write select at wrong position");
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned N     = 1 << ADDR_W
) (
  input  logic [N-1:0][WORD_W-1:0] regs,
  input  logic [ADDR_W-1:0]        addr,
  output logic [WORD_W-1:0]        data
);
  // Entry 0 is forced to zero at the selector as well as in storage.
  assign data = (addr == '0) ? '0 : regs[addr];
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w
  import regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RB_ADDR_W-1:0] wr_addr,
  input  logic [RB_WORD_W-1:0] wr_data,
  input  logic [RB_ADDR_W-1:0] rd_addr_a,
  output logic [RB_WORD_W-1:0] rd_data_a,
  input  logic [RB_ADDR_W-1:0] rd_addr_b,
  output logic [RB_WORD_W-1:0] rd_data_b
);
  logic [RB_ENTRIES-1:0]                wsel;
  logic [RB_ENTRIES-1:0][RB_WORD_W-1:0] regs;

  regbank_wsel #(.ADDR_W(RB_ADDR_W)) u_wsel (
    .clk(clk), .rst(rst), .en(wr_en), .addr(wr_addr), .sel(wsel)
  );

  assign regs[0] = '0;
  for (genvar i = 1; i < RB_ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)          regs[i] <= '0;
      else if (wsel[i]) regs[i] <= wr_data;
    end
  end

  regbank_rdmux #(.ADDR_W(RB_ADDR_W), .WORD_W(RB_WORD_W)) u_rda (
    .regs(regs), .addr(rd_addr_a), .data(rd_data_a)
  );
  regbank_rdmux #(.ADDR_W(RB_ADDR_W), .WORD_W(RB_WORD_W)) u_rdb (
    .regs(regs), .addr(rd_addr_b), .data(rd_data_b)
  );

  p_zero_a_r5: assert property (@(posedge clk) disable iff (rst) rd_addr_a == '0 |-> rd_data_a == '0)
    else $error("port A entry 0 nonzero");
  p_zero_b_r5: assert property (@(posedge clk) disable iff (rst) rd_addr_b == '0 |-> rd_data_b == '0)
    else $error("port B entry 0 nonzero");
  p_same_addr_r6: assert property (@(posedge clk) disable iff (rst) rd_addr_a == rd_addr_b |-> rd_data_a == rd_data_b)
    else $error("ports disagree on same address");
  p_hold_r3: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(regs))
    else $error("contents changed without strobe");
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_addr != '0 |=> regs[$past(wr_addr)] == $past(wr_data))
    else $error("write not captured");
endmodule

// File: tb/regbank_2r1w_tb.sv
module regbank_2r1w_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr_a = 0, rd_addr_b = 0;
  logic [31:0] wr_data = 0, rd_data_a, rd_data_b;
  logic [31:0] model [32];
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_2r1w dut_i (.*);

  function automatic logic [31:0] pattern(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (k << 7) ^ 32'h5A5A0001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i); #1;
      chk(req, rd_data_a, model[i]);
      chk(req, rd_data_b, model[31 - i]);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit en);
    @(negedge clk); wr_en = en; wr_addr = 5'(a); wr_data = d;
    @(posedge clk); #1; wr_en = 0;
    if (en && a != 0) model[a] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    // R1: reset clears every entry.
    @(negedge clk); rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    sweep("R1");
    // R2 / R8: write each address in turn, both even and odd, then check all.
    for (int a = 0; a < 32; a++) begin
      wr(a, pattern(a), 1);
      sweep("R2 R8");
    end
    // R5: writes to entry 0 are ignored.
    wr(0, 32'hFFFF_FFFF, 1);
    rd_addr_a = 0; rd_addr_b = 0; #1;
    chk("R5", rd_data_a, 0); chk("R5", rd_data_b, 0);
    // R3: strobe low changes nothing.
    for (int a = 0; a < 32; a++) wr(a, ~pattern(a), 0);
    sweep("R3");
    // R6: equal addresses on both ports.
    for (int a = 0; a < 32; a++) begin
      rd_addr_a = 5'(a); rd_addr_b = 5'(a); #1;
      chk("R6", rd_data_a, model[a]); chk("R6", rd_data_b, model[a]);
    end
    // R7: same-cycle read returns old value, then new value after the edge.
    for (int a = 1; a < 32; a += 5) begin
      @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = pattern(a + 40);
      rd_addr_a = 5'(a); rd_addr_b = 5'(a); #1;
      chk("R7", rd_data_a, model[a]); chk("R7", rd_data_b, model[a]);
      @(posedge clk); #1; wr_en = 0; model[a] = pattern(a + 40);
      chk("R7", rd_data_a, model[a]); chk("R7", rd_data_b, model[a]);
    end
    sweep("R2");
    // R1: reset after use clears again.
    @(negedge clk); rst = 1; @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 32; i++) model[i] = 0;
    sweep("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule